// File: doc/BRIEF.md
# Display Memory Access Port with Read Holder

This block connects a decoded host command stream to a display memory of 65 rows by 132 columns. The memory is arranged as byte-wide pages: each byte covers eight vertically adjacent pixels in one column, and bit k of page p is pixel row 8p+k. A stored 1 turns a pixel on and a stored 0 leaves it off. The block keeps the page and column address registers and a one-byte holding register. Every host byte, in either direction, passes through that register. The memory itself sits outside the block and is reached through a simple port that reads combinationally and writes on the clock edge.

Writes go to the holding register first. In the cycle after the request, the byte moves to the memory at the current address. Reads are pipelined one deep. A read hands the host whatever the holding register already contains, then refills the register from the current address. For this reason the first read after any address change returns stale data, and the byte at the new address only comes back on the second read. After each data access the column moves up by one. It stops at the last column and does not wrap. The host sees a single busy cycle while the memory access takes place.

Top module: `disp_ram_port`

## Requirements
- R1: After a synchronous reset the page and column are 0, busy is low, the memory port is idle and the read byte is 0x00.
- R2: A write request loads `wdata` into the holding register. In the next cycle `ram_en` and `ram_we` are high, and the held byte is written to `ram_page`/`ram_col`. The column then advances, so back-to-back writes fill consecutive columns with no extra cycle between them.
- R3: A read request sets `rdata` to the holding-register contents on the request edge. In the next cycle the holding register is refilled from memory at the current address, and the column advances.
- R4: The first read after a page or column set returns the stale holding-register byte. The second read returns the byte stored at the address that was set.
- R5: The column saturates at 131. An access at column 131 leaves the column at 131.
- R6: While the column is 132 or above, or the page is 9 or above, a data access does not assert `ram_en`. Memory, the column and the holding register are left unchanged, except that a write request still loads the holding register.
- R7: Page 8 holds only row 64. Writes to page 8 clear bits 7:1 of `ram_wdata`, and reads from page 8 return bits 7:1 as zero.
- R8: `busy` is high for exactly the one cycle after each accepted write or read request. It is never high after a page or column set.
- R9: Any request that arrives while `busy` is high is ignored.
- R10: When several requests arrive together, only one is accepted, in the order page set, then column set, then write, then read. The page value is `addr_val[3:0]` and the column value is `addr_val[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_page_req | input | 1 | Load page register from `addr_val[3:0]` |
| set_col_req | input | 1 | Load column register from `addr_val` |
| addr_val | input | 8 | Address value for page or column set |
| wr_req | input | 1 | Write `wdata` through the holding register |
| rd_req | input | 1 | Read request (pipelined through holding register) |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Byte handed to the host by the last read |
| busy | output | 1 | Memory access cycle in progress |
| ram_en | output | 1 | Memory access enable |
| ram_we | output | 1 | Memory write enable |
| ram_page | output | 4 | Memory page address (current page register) |
| ram_col | output | 8 | Memory column address (current column register) |
| ram_wdata | output | 8 | Byte written to memory |
| ram_rdata | input | 8 | Combinational read byte from memory |

## Verification
Some rules can be checked at every clock edge, and the in-line assertions cover those. Busy lasts one cycle, the page holds still while busy, and the memory port is never enabled at an out-of-range address. A presented byte equals the previous holding-register value. The column steps by one or stays at its ceiling, and bits 7:1 of a page-8 write are zero. Other behaviour only shows up in a sequence of host operations, so the bench scenarios cover it. That includes the stale first read after an address set, the data order across consecutive accesses, ignored requests and priority among simultaneous requests. The bench observes these through its own memory model and the read bytes.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic set_page;
        logic set_col;
        logic wr;
        logic rd;
    } req_t;

    // Fixed priority: page set, column set, write, read.
    function automatic req_t pick_req(input req_t r);
        req_t g;
        g = '0;
        if (r.set_page)     g.set_page = 1'b1;
        else if (r.set_col) g.set_col  = 1'b1;
        else if (r.wr)      g.wr       = 1'b1;
        else if (r.rd)      g.rd       = 1'b1;
        return g;
    endfunction

    function automatic int unsigned pages_for(input int unsigned rows);
        return (rows + 7) / 8;
    endfunction

endpackage

// File: rtl/disp_seq.sv
module disp_seq
    import disp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_t      req_in,
    output req_t      grant,
    output acc_kind_e acc_q,
    output logic      busy
);

    assign busy  = (acc_q != ACC_NONE);
    assign grant = busy ? '0 : pick_req(req_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ACC_NONE;
        end else if (grant.wr) begin
            acc_q <= ACC_WRITE;
        end else if (grant.rd) begin
            acc_q <= ACC_READ;
        end else begin
            acc_q <= ACC_NONE;
        end
    end

    // R8
    busy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

endmodule

// File: rtl/disp_addr.sv
module disp_addr #(
    parameter int NCOL   = 132,
    parameter int NPAGE  = 9,
    parameter int COL_W  = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_page,
    input  logic              set_col,
    input  logic [COL_W-1:0]  val,
    input  logic              adv,
    output logic [PAGE_W-1:0] page_q,
    output logic [COL_W-1:0]  col_q,
    output logic              in_range
);

    localparam logic [COL_W-1:0]  LAST_COL = COL_W'(NCOL - 1);
    localparam logic [COL_W-1:0]  COL_LIM  = COL_W'(NCOL);
    localparam logic [PAGE_W-1:0] PAGE_LIM = PAGE_W'(NPAGE);

    assign in_range = (page_q < PAGE_LIM) && (col_q < COL_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            col_q  <= '0;
        end else begin
            if (set_page) page_q <= val[PAGE_W-1:0];
            if (set_col) begin
                col_q <= val;
            end else if (adv && col_q != LAST_COL) begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // R5
    col_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && col_q == LAST_COL) |=> col_q == LAST_COL);

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && col_q != LAST_COL) |=> col_q == $past(col_q) + 1'b1);

endmodule

// File: rtl/disp_holder.sv
module disp_holder #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_wr,
    input  logic [DW-1:0] wr_byte,
    input  logic          ld_rd,
    input  logic [DW-1:0] rd_byte,
    input  logic          present,
    output logic [DW-1:0] holder_q,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            holder_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (ld_wr)      holder_q <= wr_byte;
            else if (ld_rd) holder_q <= rd_byte;
            if (present)    rdata_q  <= holder_q;
        end
    end

    // R3
    present_old_chk: assert property (@(posedge clk) disable iff (rst)
        present |=> rdata_q == $past(holder_q));

    // R6
    holder_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && !ld_rd) |=> $stable(holder_q));

endmodule

// File: rtl/disp_ram_port.sv
module disp_ram_port
    import disp_pkg::*;
#(
    parameter  int NCOL   = 132,
    parameter  int NROW   = 65,
    localparam int NPAGE  = int'(pages_for(NROW)),
    localparam int PAGE_W = $clog2(NPAGE),
    localparam int COL_W  = $clog2(NCOL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_page_req,
    input  logic              set_col_req,
    input  logic [COL_W-1:0]  addr_val,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [COL_W-1:0]  ram_col,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);

    localparam int               LAST_ROWS = NROW - 8 * (NPAGE - 1);
    localparam logic [7:0]       LAST_MASK = 8'((1 << LAST_ROWS) - 1);
    localparam logic [PAGE_W-1:0] LAST_PG  = PAGE_W'(NPAGE - 1);

    req_t      req_in;
    req_t      grant;
    acc_kind_e acc_q;
    logic      in_range;
    logic      hit;
    logic      last_page;
    logic [7:0] holder;
    logic [7:0] rd_masked;

    assign req_in.set_page = set_page_req;
    assign req_in.set_col  = set_col_req;
    assign req_in.wr       = wr_req;
    assign req_in.rd       = rd_req;

    disp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .grant  (grant),
        .acc_q  (acc_q),
        .busy   (busy)
    );

    disp_addr #(
        .NCOL   (NCOL),
        .NPAGE  (NPAGE),
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .set_page (grant.set_page),
        .set_col  (grant.set_col),
        .val      (addr_val),
        .adv      (hit),
        .page_q   (ram_page),
        .col_q    (ram_col),
        .in_range (in_range)
    );

    assign hit       = busy && in_range;
    assign last_page = (ram_page == LAST_PG);
    assign rd_masked = last_page ? (ram_rdata & LAST_MASK) : ram_rdata;

    disp_holder #(.DW(8)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .ld_wr    (grant.wr),
        .wr_byte  (wdata),
        .ld_rd    (hit && acc_q == ACC_READ),
        .rd_byte  (rd_masked),
        .present  (grant.rd),
        .holder_q (holder),
        .rdata_q  (rdata)
    );

    assign ram_en    = hit;
    assign ram_we    = hit && (acc_q == ACC_WRITE);
    assign ram_wdata = last_page ? (holder & LAST_MASK) : holder;

    // R6
    range_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> (ram_col < COL_W'(NCOL)) && (ram_page < PAGE_W'(NPAGE)));

    // R7
    last_page_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_page == LAST_PG) |-> (ram_wdata & ~LAST_MASK) == 8'h00);

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ram_page));

    // R8
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !busy && !set_page_req && !set_col_req) |=> busy);

endmodule

// File: tb/sim_disp_ram_port.sv
`timescale 1ns/1ps
module sim_disp_ram_port;

    localparam int NC = 132;
    localparam int NP = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_page_req = 0, set_col_req = 0, wr_req = 0, rd_req = 0;
    logic [7:0] addr_val = 0, wdata = 0;
    logic [7:0] rdata, ram_wdata, ram_col;
    logic [7:0] ram_rdata;
    logic [3:0] ram_page;
    logic       busy, ram_en, ram_we;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem [NP][NC];

    always #4 clk = ~clk;

    disp_ram_port u0 (
        .clk(clk), .rst(rst),
        .set_page_req(set_page_req), .set_col_req(set_col_req),
        .addr_val(addr_val), .wr_req(wr_req), .rd_req(rd_req),
        .wdata(wdata), .rdata(rdata), .busy(busy),
        .ram_en(ram_en), .ram_we(ram_we), .ram_page(ram_page),
        .ram_col(ram_col), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Memory model: combinational read, write on edge
    always_comb begin
        if (int'(ram_page) < NP && int'(ram_col) < NC) ram_rdata = mem[ram_page][ram_col];
        else ram_rdata = 8'h00;
    end

    always @(posedge clk) begin
        if (ram_en && ram_we && int'(ram_page) < NP && int'(ram_col) < NC)
            mem[ram_page][ram_col] <= ram_wdata;
    end

    localparam logic [1:0] OP_SP = 2'd0, OP_SC = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

    // {op, value, expected read byte}
    localparam logic [17:0] TBL [16] = '{
        {OP_SP, 8'd2,   8'h00},
        {OP_SC, 8'd10,  8'h00},
        {OP_WR, 8'hA5,  8'h00},
        {OP_WR, 8'h3C,  8'h00},
        {OP_WR, 8'h7E,  8'h00},
        {OP_SC, 8'd10,  8'h00},
        {OP_RD, 8'h00,  8'h7E},
        {OP_RD, 8'h00,  8'hA5},
        {OP_RD, 8'h00,  8'h3C},
        {OP_RD, 8'h00,  8'h7E},
        {OP_SP, 8'd8,   8'h00},
        {OP_SC, 8'd0,   8'h00},
        {OP_WR, 8'hFF,  8'h00},
        {OP_SC, 8'd0,   8'h00},
        {OP_RD, 8'h00,  8'hFF},
        {OP_RD, 8'h00,  8'h01}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        set_page_req = 0; set_col_req = 0; wr_req = 0; rd_req = 0;
    endtask

    // Drive one request for one edge; returns at the negedge after that edge
    task automatic issue(input logic [1:0] op, input logic [7:0] v);
        @(negedge clk);
        addr_val = v; wdata = v;
        case (op)
            OP_SP: set_page_req = 1;
            OP_SC: set_col_req  = 1;
            OP_WR: wr_req       = 1;
            default: rd_req     = 1;
        endcase
        @(negedge clk);
        clear_in();
    endtask

    task automatic full(input logic [1:0] op, input logic [7:0] v);
        issue(op, v);
        if (op == OP_WR || op == OP_RD) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++) mem[p][c] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ram_en", ram_en, 0);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 page", ram_page, 0);
        chk("R1 col", ram_col, 0);

        // Table: R2 writes, R3/R4 read pipeline, R7 last page
        for (int i = 0; i < 16; i++) begin
            full(TBL[i][17:16], TBL[i][15:8]);
            if (TBL[i][17:16] == OP_RD)
                chk($sformatf("R3/R4/R7 table step %0d", i), rdata, TBL[i][7:0]);
        end
        chk("R2 mem col10", mem[2][10], 8'hA5);
        chk("R2 mem col11", mem[2][11], 8'h3C);
        chk("R2 mem col12", mem[2][12], 8'h7E);
        chk("R7 page8 stored", mem[8][0], 8'h01);
        chk("R3 column after reads", ram_col, 8'd2);

        // R8 busy timing, R2 port signals
        full(OP_SP, 8'd3);
        issue(OP_SC, 8'd20);
        chk("R8 no busy after set", busy, 0);
        issue(OP_WR, 8'h12);
        chk("R8 busy high", busy, 1);
        chk("R2 ram_we", ram_we, 1);
        chk("R2 ram_en", ram_en, 1);
        chk("R2 ram_col", ram_col, 8'd20);
        chk("R2 ram_wdata", ram_wdata, 8'h12);
        // R9: requests during busy are ignored
        addr_val = 8'd50; wdata = 8'h99; set_col_req = 1; wr_req = 1;
        @(negedge clk);
        clear_in();
        chk("R8 busy low", busy, 0);
        chk("R9 col not reloaded", ram_col, 8'd21);
        chk("R9 no second access", ram_en, 0);
        @(negedge clk);
        chk("R9 mem untouched", mem[3][21], 8'h00);
        chk("R2 mem written", mem[3][20], 8'h12);

        // R5 saturation
        full(OP_SC, 8'd131);
        full(OP_WR, 8'h11);
        chk("R5 col holds", ram_col, 8'd131);
        full(OP_WR, 8'h22);
        chk("R5 mem 131", mem[3][131], 8'h22);
        chk("R5 col still", ram_col, 8'd131);
        chk("R5 no wrap write", mem[3][0], 8'h00);

        // R6 out-of-range column and page
        full(OP_SC, 8'd140);
        issue(OP_WR, 8'h55);
        chk("R6 busy", busy, 1);
        chk("R6 no ram_en col", ram_en, 0);
        @(negedge clk);
        chk("R6 col kept", ram_col, 8'd140);
        full(OP_RD, 8'h00);
        chk("R6 read holder", rdata, 8'h55);
        full(OP_RD, 8'h00);
        chk("R6 holder unchanged", rdata, 8'h55);
        full(OP_SP, 8'd9);
        full(OP_SC, 8'd0);
        issue(OP_WR, 8'h66);
        chk("R6 no ram_en page", ram_en, 0);
        @(negedge clk);
        chk("R6 no alias write", mem[1][0], 8'h00);

        // R10 priority
        full(OP_SP, 8'd4);
        full(OP_SC, 8'd5);
        @(negedge clk);
        addr_val = 8'd6; set_page_req = 1; set_col_req = 1; wr_req = 1; rd_req = 1;
        @(negedge clk);
        clear_in();
        chk("R10 page wins busy", busy, 0);
        chk("R10 page set", ram_page, 4'd6);
        chk("R10 col kept", ram_col, 8'd5);
        addr_val = 8'd7; set_col_req = 1; wr_req = 1;
        @(negedge clk);
        clear_in();
        chk("R10 col wins busy", busy, 0);
        chk("R10 col set", ram_col, 8'd7);
        wdata = 8'h77; wr_req = 1; rd_req = 1;
        @(negedge clk);
        clear_in();
        chk("R10 write wins", ram_we, 1);
        chk("R10 read not taken", rdata, 8'h55);
        @(negedge clk);
        chk("R10 mem", mem[6][7], 8'h77);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule